// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block is the host side of a 3-wire serial EEPROM holding 64 words of 16 bits. It drives the chip select, serial clock and serial data output pins, and samples the serial data line returned by the memory. A request port carries a read or write flag, a 6-bit word address and, for writes, a 16-bit word. When the transfer finishes the block pulses `done_o` for one cycle, presents the read word on `rdata_o` and flags a busy-poll timeout on `err_o`.

Every pin change is one "step", and every step is held for exactly `DLY` system clock cycles. A read is one framed command followed by 16 clocked-in bits. A write is framed by an enable command before it and a disable command after it, each padded with zero bits; the write itself is followed by a standby sequence and polling of the returned data line until the memory reports completion, bounded by `POLL_MAX` tries.

Top module: `mw_eeprom_master`

## Requirements
- R1: During and right after reset, `cs_o`, `sk_o` and `di_o` are low, `ready_o` is high, `done_o` and `err_o` are low.
- R2: A request is accepted only on a clock edge where `req_valid_i` and `ready_o` are both high; a request raised while busy is ignored, and with no request the pins stay unchanged while idle.
- R3: The first pin state of a transfer appears at the accepting edge, and every pin state (cs, sk, di) is then held for exactly `DLY` cycles before the next one.
- R4: Every transfer opens with state (cs,sk,di)=(0,0,0), followed by (1,0,0).
- R5: A field is sent most significant bit first; each bit b takes three states (1,0,b), (1,1,b), (1,0,b), and the field is followed by one state (1,0,0).
- R6: A read sends opcode 3'b110 then the 6-bit address, then clocks in 16 bits, each as state (1,1,0) then (1,0,0); `do_i` is sampled at the end of the (1,1,0) state, first bit into the most significant position of `rdata_o`.
- R7: The standby sequence is the four states (0,0,0), (0,1,0), (1,1,0), (1,0,0).
- R8: A write sends, in order: the opening of R4, field 5'b10011, four zero bits, standby, field 3'b101, the address, the 16 data bits, standby, polling, standby, field 5'b10000, four zero bits, cleanup.
- R9: Each poll is one state (1,0,0); `do_i` is sampled at its end, polling stops after the first poll that sees `do_i` high, and at most `POLL_MAX` polls are made.
- R10: If no poll sees `do_i` high, `err_o` is high at `done_o` and the rest of the write sequence still runs.
- R11: A write ends with the cleanup states (0,0,0), (0,1,0), (0,0,0), and the pins stay at (0,0,0) afterwards.
- R12: A read ends with standby, and the pins stay at (1,0,0) afterwards.
- R13: `done_o` is high for exactly one cycle, one cycle after the last state's interval ends, together with `ready_o`; `err_o` is valid with it and is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Word to write |
| ready_o | output | 1 | Idle, a request can be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Busy-poll timeout of the last write |
| rdata_o | output | DW | Word returned by the last read |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
The bench builds the block with `DLY` = 3 and `POLL_MAX` = 5. A three-cycle interval makes every state's hold length visible to a per-cycle compare while keeping each transfer to a few hundred cycles. The small poll limit brings both the last allowed poll and the full timeout with its error flag and continued disable sequence within a short run, next to first-try completion.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    SEG_SETUP, SEG_OUT, SEG_IN, SEG_STBY, SEG_POLL, SEG_CLEAN, SEG_END
  } seg_kind_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } pins_t;
endpackage

// File: rtl/mw_delay_timer.sv
module mw_delay_timer #(
  parameter int unsigned DLY = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);
  localparam int unsigned TW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(DLY - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD); // R3
endmodule

// File: rtl/mw_capture.sv
module mw_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (clr_i)   data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end

  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !clr_i) |=> $stable(data_o)); // R6
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int unsigned DLY      = 2500,
  parameter int unsigned POLL_MAX = 200,
  parameter int unsigned AW       = 6,
  parameter int unsigned DW       = 16,
  parameter int unsigned PAD_BITS = 4,
  parameter logic [2:0]  OP_READ  = 3'b110,
  parameter logic [2:0]  OP_WRITE = 3'b101,
  parameter logic [4:0]  OP_EWEN  = 5'b10011,
  parameter logic [4:0]  OP_EWDS  = 5'b10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic          cs_o,
  output logic          sk_o,
  output logic          di_o,
  input  logic          do_i
);
  localparam int unsigned FW   = DW;
  localparam int unsigned BIW  = $clog2(FW);
  localparam int unsigned NBW  = $clog2(FW + 1);
  localparam int unsigned PW   = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int unsigned SEGW = 4;

  typedef struct packed {
    seg_kind_e      kind;
    logic [NBW-1:0] nbits;
    logic [FW-1:0]  data;
  } seg_t;

  function automatic seg_t mk(input seg_kind_e k, input int unsigned n, input logic [FW-1:0] d);
    seg_t s;
    s.kind  = k;
    s.nbits = NBW'(n);
    s.data  = d;
    return s;
  endfunction

  // transfer script: segment list per command
  function automatic seg_t seg_of(input logic wr, input logic [SEGW-1:0] idx,
                                  input logic [AW-1:0] a, input logic [DW-1:0] d);
    seg_t s;
    s = mk(SEG_END, 0, '0);
    if (!wr) begin
      case (idx)
        4'd0: s = mk(SEG_SETUP, 0, '0);
        4'd1: s = mk(SEG_OUT, 3, FW'(OP_READ));
        4'd2: s = mk(SEG_OUT, AW, FW'(a));
        4'd3: s = mk(SEG_IN, DW, '0);
        4'd4: s = mk(SEG_STBY, 0, '0);
        default: ;
      endcase
    end else begin
      case (idx)
        4'd0:  s = mk(SEG_SETUP, 0, '0);
        4'd1:  s = mk(SEG_OUT, 5, FW'(OP_EWEN));
        4'd2:  s = mk(SEG_OUT, PAD_BITS, '0);
        4'd3:  s = mk(SEG_STBY, 0, '0);
        4'd4:  s = mk(SEG_OUT, 3, FW'(OP_WRITE));
        4'd5:  s = mk(SEG_OUT, AW, FW'(a));
        4'd6:  s = mk(SEG_OUT, DW, FW'(d));
        4'd7:  s = mk(SEG_STBY, 0, '0);
        4'd8:  s = mk(SEG_POLL, 0, '0);
        4'd9:  s = mk(SEG_STBY, 0, '0);
        4'd10: s = mk(SEG_OUT, 5, FW'(OP_EWDS));
        4'd11: s = mk(SEG_OUT, PAD_BITS, '0);
        4'd12: s = mk(SEG_CLEAN, 0, '0);
        default: ;
      endcase
    end
    return s;
  endfunction

  function automatic pins_t pins_of(input seg_t s, input logic [BIW-1:0] b, input logic [1:0] sub);
    pins_t p;
    p = '0;
    case (s.kind)
      SEG_SETUP: p = (sub == 2'd0) ? 3'b000 : 3'b100;
      SEG_OUT:   p = (sub == 2'd3) ? 3'b100 : {1'b1, sub == 2'd1, s.data[b]};
      SEG_IN:    p = {1'b1, sub == 2'd0, 1'b0};
      SEG_STBY: begin
        case (sub)
          2'd0: p = 3'b000;
          2'd1: p = 3'b010;
          2'd2: p = 3'b110;
          default: p = 3'b100;
        endcase
      end
      SEG_POLL:  p = 3'b100;
      SEG_CLEAN: p = {1'b0, sub == 2'd1, 1'b0};
      default:   p = '0;
    endcase
    return p;
  endfunction

  logic            busy_q, wr_q, err_q, done_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [SEGW-1:0] seg_q, seg_n;
  logic [BIW-1:0]  bit_q, bit_n;
  logic [1:0]      sub_q, sub_n;
  logic [PW-1:0]   poll_q, poll_n;
  pins_t           pins_q, pins_nx;
  seg_t            seg_cur, seg_nxt;
  logic            accept, advance, tmr_zero;
  logic            seg_end, set_err, cap, finish;

  assign accept  = req_valid_i && !busy_q;
  assign advance = busy_q && tmr_zero;

  mw_delay_timer #(.DLY(DLY)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept || advance),
    .run_i  (busy_q),
    .zero_o (tmr_zero)
  );

  mw_capture #(.W(DW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .shift_i (advance && cap),
    .bit_i   (do_i),
    .data_o  (rdata_o)
  );

  always_comb begin
    seg_cur = seg_of(wr_q, seg_q, addr_q, wdata_q);
    seg_nxt = seg_of(wr_q, seg_q + 4'd1, addr_q, wdata_q);
    seg_end = 1'b0;
    set_err = 1'b0;
    cap     = 1'b0;
    bit_n   = bit_q;
    sub_n   = sub_q + 2'd1;
    poll_n  = poll_q;
    case (seg_cur.kind)
      SEG_SETUP: seg_end = (sub_q == 2'd1);
      SEG_OUT: begin
        if (sub_q == 2'd3) seg_end = 1'b1;
        else if (sub_q == 2'd2 && bit_q != '0) begin
          bit_n = bit_q - 1'b1;
          sub_n = 2'd0;
        end
      end
      SEG_IN: begin
        if (sub_q == 2'd0) cap = 1'b1;
        else if (bit_q == '0) seg_end = 1'b1;
        else begin
          bit_n = bit_q - 1'b1;
          sub_n = 2'd0;
        end
      end
      SEG_STBY: seg_end = (sub_q == 2'd3);
      SEG_POLL: begin
        sub_n = 2'd0;
        if (do_i) seg_end = 1'b1;
        else if (poll_q == PW'(POLL_MAX - 1)) begin
          seg_end = 1'b1;
          set_err = 1'b1;
        end else poll_n = poll_q + 1'b1;
      end
      SEG_CLEAN: seg_end = (sub_q == 2'd2);
      default:   seg_end = 1'b1;
    endcase
    seg_n  = seg_q;
    finish = 1'b0;
    if (seg_end) begin
      seg_n  = seg_q + 4'd1;
      bit_n  = BIW'(seg_nxt.nbits - 1'b1);
      sub_n  = 2'd0;
      finish = (seg_nxt.kind == SEG_END);
    end
    pins_nx = pins_of(seg_end ? seg_nxt : seg_cur, bit_n, sub_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      seg_q   <= '0;
      bit_q   <= '0;
      sub_q   <= '0;
      poll_q  <= '0;
      pins_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        wr_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        seg_q   <= '0;
        bit_q   <= '0;
        sub_q   <= '0;
        poll_q  <= '0;
        err_q   <= 1'b0;
        pins_q  <= 3'b000;
      end else if (advance) begin
        seg_q  <= seg_n;
        bit_q  <= bit_n;
        sub_q  <= sub_n;
        poll_q <= poll_n;
        if (set_err) err_q <= 1'b1;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pins_q <= pins_nx;
        end
      end
    end
  end

  assign ready_o = !busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign cs_o    = pins_q.cs;
  assign sk_o    = pins_q.sk;
  assign di_o    = pins_q.di;

  AST_OPEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o) |=> (!cs_o && !sk_o && !di_o)); // R4
  AST_DI_HELD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $fell(sk_o)) |-> $stable(di_o)); // R5
  AST_PIN_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({cs_o, sk_o, di_o}) |-> $past(accept || advance)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !req_valid_i) |=> $stable({cs_o, sk_o, di_o})); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o); // R13
endmodule

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;
  localparam int DLY  = 3;
  localparam int PMAX = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata;
  logic        ready, done, err;
  logic [15:0] rdata;
  logic        cs, sk, di, do_line;

  always #5 clk = ~clk;

  mw_eeprom_master #(.DLY(DLY), .POLL_MAX(PMAX)) i_mw_eeprom_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready), .done_o(done),
    .err_o(err), .rdata_o(rdata), .cs_o(cs), .sk_o(sk), .di_o(di), .do_i(do_line)
  );

  int checks = 0;
  int errors = 0;

  logic [2:0] q_pins[$];
  logic       q_do[$];
  string      q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_step(input logic c, input logic s, input logic d, input logic dv, input string tag);
    repeat (DLY) begin
      q_pins.push_back({c, s, d});
      q_do.push_back(dv);
      q_tag.push_back(tag);
    end
  endtask

  task automatic build_setup();
    push_step(0, 0, 0, 0, "R4");
    push_step(1, 0, 0, 0, "R4");
  endtask

  task automatic build_out(input logic [15:0] v, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      push_step(1, 0, v[i], 0, tag);
      push_step(1, 1, v[i], 0, tag);
      push_step(1, 0, v[i], 0, tag);
    end
    push_step(1, 0, 0, 0, tag);
  endtask

  task automatic build_in(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      push_step(1, 1, 0, v[i], "R6");
      push_step(1, 0, 0, 0, "R6");
    end
  endtask

  task automatic build_stby();
    push_step(0, 0, 0, 0, "R7");
    push_step(0, 1, 0, 0, "R7");
    push_step(1, 1, 0, 0, "R7");
    push_step(1, 0, 0, 0, "R7");
  endtask

  task automatic build_poll(input int k);
    if (k == 0) begin
      for (int i = 0; i < PMAX; i++) push_step(1, 0, 0, 0, "R10");
    end else begin
      for (int i = 0; i < k; i++) push_step(1, 0, 0, (i == k - 1), "R9");
    end
  endtask

  task automatic build_clean();
    push_step(0, 0, 0, 0, "R11");
    push_step(0, 1, 0, 0, "R11");
    push_step(0, 0, 0, 0, "R11");
  endtask

  // poll_k: poll number at which DO goes high, 0 = never
  task automatic run_txn(input logic wr, input logic [5:0] a, input logic [15:0] d,
                         input int poll_k, input bit inject);
    int idx;
    logic [2:0] idle_pins;
    if (!wr) begin
      build_setup();
      build_out(16'b110, 3, "R6");
      build_out({10'd0, a}, 6, "R5");
      build_in(d);
      build_stby();
    end else begin
      build_setup();
      build_out(16'b10011, 5, "R8");
      build_out(16'h0, 4, "R8");
      build_stby();
      build_out(16'b101, 3, "R8");
      build_out({10'd0, a}, 6, "R8");
      build_out(d, 16, "R5");
      build_stby();
      build_poll(poll_k);
      build_stby();
      build_out(16'b10000, 5, "R8");
      build_out(16'h0, 4, "R8");
      build_clean();
    end
    @(negedge clk);
    chk(ready == 1'b1, "R2", "ready before request", 32'(ready), 32'd1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wr ? d : 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0;
    while (q_pins.size() > 0) begin
      // R3: one compare per cycle against the per-step hold model
      chk({cs, sk, di} == q_pins[0], {"R3 ", q_tag[0]}, "pins cs,sk,di",
          32'({cs, sk, di}), 32'(q_pins[0]));
      do_line = q_do[0];
      void'(q_pins.pop_front());
      void'(q_do.pop_front());
      void'(q_tag.pop_front());
      if (inject && idx == 7) begin
        req_valid = 1'b1;  // R2: request while busy must be ignored
        req_write = ~wr;
        req_addr  = ~a;
      end else if (inject && idx == 8) begin
        req_valid = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    do_line = 1'b0;
    chk(done == 1'b1, "R13", "done after last interval", 32'(done), 32'd1);
    chk(ready == 1'b1, "R13", "ready with done", 32'(ready), 32'd1);
    if (wr && poll_k == 0) chk(err == 1'b1, "R10", "timeout flag", 32'(err), 32'd1);
    else chk(err == 1'b0, "R13", "error flag", 32'(err), 32'd0);
    if (!wr) chk(rdata == d, "R6", "read word", 32'(rdata), 32'(d));
    idle_pins = wr ? 3'b000 : 3'b100;
    chk({cs, sk, di} == idle_pins, wr ? "R11" : "R12", "end pins",
        32'({cs, sk, di}), 32'(idle_pins));
    @(negedge clk);
    chk(done == 1'b0, "R13", "done one cycle", 32'(done), 32'd0);
    chk({cs, sk, di} == idle_pins, "R2", "idle pins hold",
        32'({cs, sk, di}), 32'(idle_pins));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    do_line   = 1'b0;
    repeat (3) @(negedge clk);
    chk({cs, sk, di} == 3'b000, "R1", "pins in reset", 32'({cs, sk, di}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", 32'(ready), 32'd1);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(err == 1'b0, "R1", "err after reset", 32'(err), 32'd0);
    chk({cs, sk, di} == 3'b000, "R1", "pins after reset", 32'({cs, sk, di}), 32'd0);

    run_txn(1'b0, 6'h2A, 16'hA5C3, 0, 1'b1);
    run_txn(1'b0, 6'h00, 16'h8001, 0, 1'b0);
    run_txn(1'b1, 6'h15, 16'h1234, 3, 1'b0);
    run_txn(1'b1, 6'h3F, 16'hBEEF, 1, 1'b1);
    run_txn(1'b1, 6'h01, 16'h0F0F, PMAX, 1'b0);
    run_txn(1'b1, 6'h20, 16'hFFFF, 0, 1'b0);
    run_txn(1'b0, 6'h3F, 16'h7FFE, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule